// File: doc/BRIEF.md
# Write-Address Dependency Gate

This block sits on the write-address channel between one AXI4 master and a switch with several output ports. For each write it is given the target port, which is decoded elsewhere, and the AWID. It compares both against the writes still waiting for a response. It drives AWREADY low when accepting the write would break the selected ordering rule or would exceed the outstanding limit. It watches the write-response handshake to retire writes.

Two rules are available. In the one-target rule, all outstanding writes must go to the same output port. In the per-ID rule, each AWID is bound to one port while it has writes outstanding, and different AWIDs may use different ports at the same time. The decision is combinational, so a legal write passes in the cycle it is presented. A response retiring in the same cycle is counted before the decision is made.

Top module: `aw_dep_gate`

## Requirements
- R1: After reset nothing is outstanding, and a write to any port with any AWID sees aw_ready high.
- R2: With mode_sel = 0 (one-target rule), writes to the port already in use are accepted back to back, and the outstanding total never exceeds OUT_LIMIT.
- R3: With the one-target rule, a write to a port other than the one in use sees aw_ready low until every outstanding write has retired.
- R4: With mode_sel = 1 (per-ID rule), writes with different AWIDs are accepted together even when they target different ports.
- R5: With the per-ID rule, a write whose AWID has outstanding writes bound to another port sees aw_ready low until that AWID's writes have all retired. Other AWIDs are not affected.
- R6: With the per-ID rule, a write to the port its AWID is already bound to is accepted.
- R7: aw_ready is low while the outstanding total equals OUT_LIMIT. It is high in a cycle in which a response handshake (b_valid and b_ready) retires a write.
- R8: When a write handshake and a response handshake occur in the same cycle, the counts are left unchanged. If the response takes an AWID's count to zero, the new write is not stalled by that AWID's old port binding and binds the AWID to its own port.
- R9: A change of mode_sel while writes are outstanding has no effect. The new rule applies only once the outstanding total is zero.
- R10: aw_ready is decided in the same cycle that aw_valid, aw_id and aw_port are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 1 | Rule select: 0 one-target, 1 per-ID |
| aw_valid | input | 1 | Write address valid from master |
| aw_id | input | ID_W | Write AWID |
| aw_port | input | PORT_W | Decoded target output port |
| aw_ready | output | 1 | Gated write address ready to master |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready from master |
| b_id | input | ID_W | BID of the response |

## Verification
A write acceptance and a response retirement can occur in the same clock cycle. The bench provokes this in three places. The first is when the outstanding total is at its limit. The second is when the response leaves the AWID's count above zero. The third is when the response takes that count to zero while the new write targets a different port. Each case is judged by aw_ready in that cycle. The follow-up writes then show whether the count and the port binding came out right: a stall to the old port, and acceptance to the new one.

// File: rtl/dep_gate_pkg.sv
// Package: shared types for the write-address dependency gate.
package dep_gate_pkg;
    // Ordering rule applied to outstanding writes
    typedef enum logic {
        MODE_ONE_TGT = 1'b0,
        MODE_PER_ID  = 1'b1
    } dep_mode_e;
endpackage

// File: rtl/dg_id_table.sv
// Per-AWID tracker: holds an outstanding count and the bound port for each ID.
// Assumes every response names an ID with a non-zero count.
module dg_id_table #(
    parameter int ID_W   = 4,
    parameter int PORT_W = 2,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [ID_W-1:0]   acc_id,
    input  logic [PORT_W-1:0] acc_port,
    input  logic              ret,
    input  logic [ID_W-1:0]   ret_id,
    input  logic [ID_W-1:0]   q_id,
    output logic              q_busy,
    output logic [PORT_W-1:0] q_port
);
    localparam int N_ID = 1 << ID_W;

    logic [CNT_W-1:0]  cnt_q  [N_ID];
    logic [PORT_W-1:0] port_q [N_ID];

    for (genvar i = 0; i < N_ID; i++) begin : g_ent
        logic hit_a, hit_r;
        assign hit_a = acc && (acc_id == ID_W'(i));
        assign hit_r = ret && (ret_id == ID_W'(i));

        // Count and port binding for one ID
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[i]  <= '0;
                port_q[i] <= '0;
            end else begin
                if (hit_a && !hit_r)      cnt_q[i] <= cnt_q[i] + 1'b1;
                else if (hit_r && !hit_a) cnt_q[i] <= cnt_q[i] - 1'b1;
                if (hit_a) port_q[i] <= acc_port;
            end
        end
    end

    // Lookup for the queried ID, counting a same-cycle retirement
    always_comb begin
        logic [CNT_W-1:0] eff;
        eff    = cnt_q[q_id] - {{(CNT_W-1){1'b0}}, (ret && (ret_id == q_id))};
        q_busy = (eff != '0);
        q_port = port_q[q_id];
    end
endmodule

// File: rtl/dg_global.sv
// Global tracker: total outstanding count, port in use, and the mode latch.
// The mode is sampled only while nothing is outstanding.
module dg_global
    import dep_gate_pkg::*;
#(
    parameter int PORT_W    = 2,
    parameter int CNT_W     = 5,
    parameter int OUT_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              acc,
    input  logic [PORT_W-1:0] acc_port,
    input  logic              ret,
    output logic              busy,
    output logic              full,
    output logic [PORT_W-1:0] port,
    output dep_mode_e         mode
);
    logic [CNT_W-1:0]  cnt_q, cnt_eff;
    logic [PORT_W-1:0] port_q;
    dep_mode_e         mode_q;

    // Count after a same-cycle retirement
    assign cnt_eff = cnt_q - {{(CNT_W-1){1'b0}}, ret};
    assign busy    = (cnt_eff != '0);
    assign full    = (cnt_eff == CNT_W'(OUT_LIMIT));
    assign port    = port_q;
    assign mode    = (cnt_q == '0) ? dep_mode_e'(mode_sel) : mode_q;

    // Total count, port in use, and the mode held while writes are outstanding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            port_q <= '0;
            mode_q <= MODE_ONE_TGT;
        end else begin
            if (acc && !ret)      cnt_q <= cnt_q + 1'b1;
            else if (ret && !acc) cnt_q <= cnt_q - 1'b1;
            if (acc) port_q <= acc_port;
            if (cnt_q == '0) mode_q <= dep_mode_e'(mode_sel);
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(OUT_LIMIT));
    // R7
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(OUT_LIMIT) && !ret) |-> !acc);
    // R8
    same_cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ret) |=> (cnt_q == $past(cnt_q)));
    // R3
    one_tgt_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ONE_TGT && cnt_q != '0 && acc && !ret) |-> (acc_port == port_q));
endmodule

// File: rtl/aw_dep_gate.sv
// Write-address dependency gate: drives AWREADY low when a new write would
// break the selected ordering rule or exceed OUT_LIMIT. Assumes responses
// are only returned for writes that are outstanding.
module aw_dep_gate
    import dep_gate_pkg::*;
#(
    parameter int ID_W      = 4,
    parameter int PORT_W    = 2,
    parameter int OUT_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              aw_valid,
    input  logic [ID_W-1:0]   aw_id,
    input  logic [PORT_W-1:0] aw_port,
    output logic              aw_ready,
    input  logic              b_valid,
    input  logic              b_ready,
    input  logic [ID_W-1:0]   b_id
);
    localparam int CNT_W = $clog2(OUT_LIMIT + 1);

    logic              acc, ret;
    logic              g_busy, g_full, id_busy;
    logic [PORT_W-1:0] g_port, id_port;
    dep_mode_e         mode;
    logic              rule_ok;

    assign ret = b_valid && b_ready;
    assign acc = aw_valid && aw_ready;

    dg_global #(.PORT_W(PORT_W), .CNT_W(CNT_W), .OUT_LIMIT(OUT_LIMIT)) u_glb (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .acc(acc), .acc_port(aw_port), .ret(ret),
        .busy(g_busy), .full(g_full), .port(g_port), .mode(mode)
    );

    dg_id_table #(.ID_W(ID_W), .PORT_W(PORT_W), .CNT_W(CNT_W)) u_ids (
        .clk(clk), .rst_n(rst_n),
        .acc(acc), .acc_id(aw_id), .acc_port(aw_port),
        .ret(ret), .ret_id(b_id),
        .q_id(aw_id), .q_busy(id_busy), .q_port(id_port)
    );

    // Rule check for the presented write under the active mode
    always_comb begin
        if (mode == MODE_ONE_TGT) rule_ok = !g_busy || (aw_port == g_port);
        else                      rule_ok = !id_busy || (aw_port == id_port);
    end

    assign aw_ready = rule_ok && !g_full;

    // R5
    per_id_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PER_ID && acc && id_busy) |-> (aw_port == id_port));
endmodule

// File: tb/tb_aw_dep_gate.sv
// Scoreboard bench: the driver queues the expected aw_ready, the monitor compares.
module tb_aw_dep_gate;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_sel = 1'b0;
    logic aw_valid = 1'b0;
    logic [3:0] aw_id = '0;
    logic [1:0] aw_port = '0;
    logic aw_ready;
    logic b_valid = 1'b0;
    logic b_ready = 1'b1;
    logic [3:0] b_id = '0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct { logic exp; string tag; } item_t;
    item_t sb[$];
    event smp;

    always #4 clk = ~clk;

    aw_dep_gate #(.ID_W(4), .PORT_W(2), .OUT_LIMIT(4)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .aw_valid(aw_valid), .aw_id(aw_id), .aw_port(aw_port), .aw_ready(aw_ready),
        .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id)
    );

    // Monitor: pops an expected item and compares it with aw_ready
    initial forever begin
        @(smp);
        #1;
        if (sb.size() != 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (aw_ready !== it.exp) begin
                fails++;
                $display("FAIL %s aw_ready=%0b expected %0b", it.tag, aw_ready, it.exp);
            end
        end
    end

    // Driver: one cycle of stimulus with an optional expected aw_ready
    task automatic step(input logic v, input logic [3:0] id, input logic [1:0] p,
                        input logic bv, input logic [3:0] bid,
                        input logic chk, input logic exp, input string tag);
        item_t it;
        @(negedge clk);
        aw_valid = v; aw_id = id; aw_port = p;
        b_valid = bv; b_id = bid;
        if (chk) begin
            it.exp = exp; it.tag = tag;
            sb.push_back(it);
            ->smp;
        end
        @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state, one-target mode; R10 same-cycle decision
        step(1, 4'd0, 2'd0, 0, 4'd0, 1, 1, "R1 R10 first write after reset");
        step(1, 4'd1, 2'd0, 0, 4'd0, 1, 1, "R2 same port second");
        step(1, 4'd2, 2'd0, 0, 4'd0, 1, 1, "R2 same port third");
        step(1, 4'd3, 2'd1, 0, 4'd0, 1, 0, "R3 other port stalls");
        mode_sel = 1'b1;
        step(1, 4'd3, 2'd1, 0, 4'd0, 1, 0, "R9 mode change ignored");
        step(1, 4'd3, 2'd0, 0, 4'd0, 1, 1, "R2 fourth fills limit");
        step(1, 4'd4, 2'd0, 0, 4'd0, 1, 0, "R7 stall at limit");
        step(1, 4'd4, 2'd0, 1, 4'd0, 1, 1, "R7 R8 ready with same-cycle retire");
        step(0, 4'd0, 2'd0, 1, 4'd1, 0, 0, "");
        step(0, 4'd0, 2'd0, 1, 4'd2, 0, 0, "");
        step(0, 4'd0, 2'd0, 1, 4'd3, 0, 0, "");
        step(1, 4'd5, 2'd1, 0, 4'd0, 1, 0, "R3 still stalled with one left");
        step(0, 4'd0, 2'd0, 1, 4'd4, 0, 0, "");
        // per-ID mode now active
        step(1, 4'd0, 2'd1, 0, 4'd0, 1, 1, "R4 id0 to port1");
        step(1, 4'd1, 2'd2, 0, 4'd0, 1, 1, "R4 id1 to port2 overlaps");
        step(1, 4'd2, 2'd3, 0, 4'd0, 1, 1, "R4 id2 to port3 overlaps");
        step(1, 4'd0, 2'd2, 0, 4'd0, 1, 0, "R5 id0 to other port stalls");
        step(1, 4'd0, 2'd1, 0, 4'd0, 1, 1, "R6 id0 same port accepted");
        step(1, 4'd0, 2'd2, 1, 4'd0, 1, 0, "R5 R8 one id0 write left still stalls");
        step(1, 4'd0, 2'd2, 1, 4'd0, 1, 1, "R8 last id0 retire frees binding");
        step(1, 4'd0, 2'd1, 0, 4'd0, 1, 0, "R8 id0 now bound to port2");
        step(1, 4'd0, 2'd2, 0, 4'd0, 1, 1, "R6 id0 to bound port2");
        step(1, 4'd3, 2'd0, 0, 4'd0, 1, 0, "R7 limit in per-ID mode");
        step(0, 4'd0, 2'd0, 1, 4'd0, 0, 0, "");
        step(0, 4'd0, 2'd0, 1, 4'd0, 0, 0, "");
        step(0, 4'd0, 2'd0, 1, 4'd1, 0, 0, "");
        step(0, 4'd0, 2'd0, 1, 4'd2, 0, 0, "");
        mode_sel = 1'b0;
        step(1, 4'd7, 2'd3, 0, 4'd0, 1, 1, "R9 new mode after drain");
        step(1, 4'd8, 2'd2, 0, 4'd0, 1, 0, "R3 one-target rule back in force");
        step(0, 4'd0, 2'd0, 0, 4'd0, 0, 0, "");
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule